// File: doc/BRIEF.md
# Host Command Decoder with Validation

This block sits between the byte receiver of a serial host link and the control logic of a memory upset tester. It turns the bytes that have arrived into one-cycle control pulses: a system-wide hard reset, a read-out request, a clear for the particle-event counter, a memory geometry update with row and column address widths, and an error-injection request. A geometry update also tells the tester to rewrite the whole test memory with its pattern.

Every byte is checked before anything is executed. A bad parity flag, an opcode with no meaning, a geometry outside the supported range, or a multi-byte command that stalls partway produces a single error-response request with a 4-bit fault code. A faulted command has no other effect. After any fault the decoder is idle again, so the next byte is read as an opcode.

The decoder is a three-state machine. `ST_IDLE` waits for an opcode. `ST_ROW` waits for the row-width byte of a geometry command. `ST_COL` waits for the column-width byte. Its transitions are:
- **opcode-size**: IDLE to ROW.
- **row-accept**: ROW to COL.
- **col-done**: COL to IDLE.
- **abort-parity**: ROW or COL to IDLE.
- **abort-timeout**: ROW or COL to IDLE.

Top module: `host_cmd_decoder`

## Requirements
- R1: While reset is held and after it is released, every pulse output is low and `fault_code_o` is 0.
- R2: Opcode 0x01 with good parity raises `sys_reset_o` for exactly one cycle, in the cycle after the byte is accepted.
- R3: Opcode 0x02 raises `readout_o` for one cycle, in the cycle after the byte is accepted.
- R4: Opcode 0x03 raises `cnt_clear_o` for one cycle, in the cycle after the byte is accepted.
- R5: Opcode 0x05 raises `inject_o` for one cycle, in the cycle after the byte is accepted.
- R6: Opcode 0x04 is followed by a row-width byte and then a column-width byte. When both are valid, `size_set_o` pulses for one cycle after the column byte, with `size_rows_o` and `size_cols_o` carrying the two values.
- R7: The row width must lie in 10..14 and the column width in 10..13. Any other value gives fault code 3, and `size_set_o` stays low.
- R8: Any opcode other than 0x01 to 0x05 gives fault code 2.
- R9: A byte with its parity flag set gives fault code 1, whatever the state. A partial command is then dropped.
- R10: If TIMEOUT_CYC cycles pass without a byte while a geometry command is incomplete, fault code 4 is given and the command is dropped.
- R11: At most one output pulse is high in any cycle. A fault pulse carries a code from 1 to 4 and nothing else. `fault_code_o` is 0 whenever `fault_valid_o` is low.
- R12: The first byte after a fault or a completed command is decoded as an opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid_i | input | 1 | Received byte is present this cycle |
| rx_byte_i | input | 8 | Received byte |
| rx_parity_err_i | input | 1 | Parity check of the received byte failed |
| sys_reset_o | output | 1 | Hard-reset pulse |
| readout_o | output | 1 | Read-out request pulse |
| cnt_clear_o | output | 1 | Event-counter clear pulse |
| size_set_o | output | 1 | Geometry update and rewrite pulse |
| size_rows_o | output | SZ_W | Row address width, valid with size_set_o |
| size_cols_o | output | SZ_W | Column address width, valid with size_set_o |
| inject_o | output | 1 | Error-injection pulse |
| fault_valid_o | output | 1 | Error-response request pulse |
| fault_code_o | output | 4 | Fault code: 1 parity, 2 opcode, 3 size, 4 timeout |

## Verification
The hardest states to reach are the two middle states of a geometry command, since they are visible only through what happens next. The stimulus opens a geometry command and then does one of three things in ST_ROW or ST_COL: it sends a byte with a parity error, it sends an out-of-range width, or it falls silent long enough to trigger the timeout. A plain opcode follows each abort, which shows that the machine really went back to idle. The bench overrides the timeout to a short value so the silent wait stays brief.

// File: rtl/hcd_pkg.sv
package hcd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ROW  = 2'd1,
        ST_COL  = 2'd2
    } hcd_state_e;

    typedef enum logic [3:0] {
        FLT_NONE    = 4'd0,
        FLT_PARITY  = 4'd1,
        FLT_OPCODE  = 4'd2,
        FLT_SIZE    = 4'd3,
        FLT_TIMEOUT = 4'd4
    } hcd_fault_e;

    localparam logic [7:0] OP_HARD_RESET = 8'h01;
    localparam logic [7:0] OP_READOUT    = 8'h02;
    localparam logic [7:0] OP_CNT_CLEAR  = 8'h03;
    localparam logic [7:0] OP_SIZE       = 8'h04;
    localparam logic [7:0] OP_INJECT     = 8'h05;

    typedef struct packed {
        logic hard_reset;
        logic readout;
        logic cnt_clear;
        logic size;
        logic inject;
        logic unknown;
    } hcd_cmd_t;

endpackage

// File: rtl/hcd_opcode_decode.sv
module hcd_opcode_decode
    import hcd_pkg::*;
(
    input  logic [7:0] op_i,
    output hcd_cmd_t   cmd_o
);
    always_comb begin
        cmd_o            = '0;
        cmd_o.hard_reset = (op_i == OP_HARD_RESET);
        cmd_o.readout    = (op_i == OP_READOUT);
        cmd_o.cnt_clear  = (op_i == OP_CNT_CLEAR);
        cmd_o.size       = (op_i == OP_SIZE);
        cmd_o.inject     = (op_i == OP_INJECT);
        cmd_o.unknown    = !(cmd_o.hard_reset || cmd_o.readout || cmd_o.cnt_clear
                             || cmd_o.size || cmd_o.inject);
    end
endmodule

// File: rtl/hcd_range_check.sv
module hcd_range_check #(
    parameter int LO = 10,
    parameter int HI = 14
) (
    input  logic [7:0] val_i,
    output logic       ok_o
);
    localparam logic [7:0] LO_B = 8'(LO);
    localparam logic [7:0] HI_B = 8'(HI);

    assign ok_o = (val_i >= LO_B) && (val_i <= HI_B);
endmodule

// File: rtl/hcd_timeout.sv
module hcd_timeout #(
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    output logic expired_o
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    assign expired_o = (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear_i) begin
            cnt_q <= '0;
        end else if (!expired_o) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/host_cmd_decoder.sv
module host_cmd_decoder
    import hcd_pkg::*;
#(
    parameter int ROW_MIN     = 10,
    parameter int ROW_MAX     = 14,
    parameter int COL_MIN     = 10,
    parameter int COL_MAX     = 13,
    parameter int SZ_W        = 4,
    parameter int TIMEOUT_CYC = 1000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rx_valid_i,
    input  logic [7:0]      rx_byte_i,
    input  logic            rx_parity_err_i,
    output logic            sys_reset_o,
    output logic            readout_o,
    output logic            cnt_clear_o,
    output logic            size_set_o,
    output logic [SZ_W-1:0] size_rows_o,
    output logic [SZ_W-1:0] size_cols_o,
    output logic            inject_o,
    output logic            fault_valid_o,
    output logic [3:0]      fault_code_o
);
    hcd_state_e state_q, state_d;
    hcd_cmd_t   cmd;
    logic [7:0] row_q;
    logic       row_ok, col_ok, tmo;
    logic       good_byte;

    assign good_byte = rx_valid_i && !rx_parity_err_i;

    hcd_opcode_decode u_dec (.op_i(rx_byte_i), .cmd_o(cmd));

    hcd_range_check #(.LO(ROW_MIN), .HI(ROW_MAX)) u_row_chk (.val_i(row_q),     .ok_o(row_ok));
    hcd_range_check #(.LO(COL_MIN), .HI(COL_MAX)) u_col_chk (.val_i(rx_byte_i), .ok_o(col_ok));

    hcd_timeout #(.LIMIT(TIMEOUT_CYC)) u_tmo (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  ((state_q == ST_IDLE) || rx_valid_i),
        .expired_o(tmo)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (good_byte && cmd.size) state_d = ST_ROW;
            ST_ROW: begin
                if (rx_valid_i) state_d = rx_parity_err_i ? ST_IDLE : ST_COL;
                else if (tmo)   state_d = ST_IDLE;
            end
            ST_COL:  if (rx_valid_i || tmo) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // row width holding register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           row_q <= '0;
        else if (state_q == ST_ROW && good_byte) row_q <= rx_byte_i;
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sys_reset_o   <= 1'b0;
            readout_o     <= 1'b0;
            cnt_clear_o   <= 1'b0;
            size_set_o    <= 1'b0;
            size_rows_o   <= '0;
            size_cols_o   <= '0;
            inject_o      <= 1'b0;
            fault_valid_o <= 1'b0;
            fault_code_o  <= FLT_NONE;
        end else begin
            sys_reset_o   <= 1'b0;
            readout_o     <= 1'b0;
            cnt_clear_o   <= 1'b0;
            size_set_o    <= 1'b0;
            inject_o      <= 1'b0;
            fault_valid_o <= 1'b0;
            fault_code_o  <= FLT_NONE;
            unique case (state_q)
                ST_IDLE: begin
                    if (rx_valid_i) begin
                        if (rx_parity_err_i) begin
                            fault_valid_o <= 1'b1;
                            fault_code_o  <= FLT_PARITY;
                        end else if (cmd.unknown) begin
                            fault_valid_o <= 1'b1;
                            fault_code_o  <= FLT_OPCODE;
                        end else begin
                            sys_reset_o <= cmd.hard_reset;
                            readout_o   <= cmd.readout;
                            cnt_clear_o <= cmd.cnt_clear;
                            inject_o    <= cmd.inject;
                        end
                    end
                end
                ST_ROW: begin
                    if (rx_valid_i) begin
                        if (rx_parity_err_i) begin
                            fault_valid_o <= 1'b1;
                            fault_code_o  <= FLT_PARITY;
                        end
                    end else if (tmo) begin
                        fault_valid_o <= 1'b1;
                        fault_code_o  <= FLT_TIMEOUT;
                    end
                end
                ST_COL: begin
                    if (rx_valid_i) begin
                        if (rx_parity_err_i) begin
                            fault_valid_o <= 1'b1;
                            fault_code_o  <= FLT_PARITY;
                        end else if (row_ok && col_ok) begin
                            size_set_o  <= 1'b1;
                            size_rows_o <= row_q[SZ_W-1:0];
                            size_cols_o <= rx_byte_i[SZ_W-1:0];
                        end else begin
                            fault_valid_o <= 1'b1;
                            fault_code_o  <= FLT_SIZE;
                        end
                    end else if (tmo) begin
                        fault_valid_o <= 1'b1;
                        fault_code_o  <= FLT_TIMEOUT;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/hcd_checker.sv
module hcd_checker #(
    parameter int ROW_MIN = 10,
    parameter int ROW_MAX = 14,
    parameter int COL_MIN = 10,
    parameter int COL_MAX = 13,
    parameter int SZ_W    = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            rx_valid_i,
    input logic            rx_parity_err_i,
    input logic            sys_reset_o,
    input logic            readout_o,
    input logic            cnt_clear_o,
    input logic            size_set_o,
    input logic [SZ_W-1:0] size_rows_o,
    input logic [SZ_W-1:0] size_cols_o,
    input logic            inject_o,
    input logic            fault_valid_o,
    input logic [3:0]      fault_code_o
);
    assert_one_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sys_reset_o, readout_o, cnt_clear_o, size_set_o, inject_o, fault_valid_o}));

    assert_code_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
        fault_valid_o |-> (fault_code_o >= 4'd1 && fault_code_o <= 4'd4));

    assert_quiet_code_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_valid_o |-> (fault_code_o == 4'd0));

    assert_parity_fault_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid_i && rx_parity_err_i) |=> (fault_valid_o && fault_code_o == 4'd1));

    assert_size_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        size_set_o |-> (int'(size_rows_o) >= ROW_MIN && int'(size_rows_o) <= ROW_MAX
                        && int'(size_cols_o) >= COL_MIN && int'(size_cols_o) <= COL_MAX));
endmodule

bind host_cmd_decoder hcd_checker #(
    .ROW_MIN(ROW_MIN), .ROW_MAX(ROW_MAX), .COL_MIN(COL_MIN), .COL_MAX(COL_MAX), .SZ_W(SZ_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .rx_valid_i     (rx_valid_i),
    .rx_parity_err_i(rx_parity_err_i),
    .sys_reset_o    (sys_reset_o),
    .readout_o      (readout_o),
    .cnt_clear_o    (cnt_clear_o),
    .size_set_o     (size_set_o),
    .size_rows_o    (size_rows_o),
    .size_cols_o    (size_cols_o),
    .inject_o       (inject_o),
    .fault_valid_o  (fault_valid_o),
    .fault_code_o   (fault_code_o)
);

// File: tb/host_cmd_decoder_tb.sv
`timescale 1ns/1ps
module host_cmd_decoder_tb;
    localparam int TMO = 24;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = '0;
    logic       rx_par = 1'b0;
    logic       sys_reset, readout, cnt_clear, size_set, inject, fault_valid;
    logic [3:0] rows, cols, fault_code;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // kinds: 0 reset, 1 readout, 2 clear, 3 size, 4 inject, 5 fault
    typedef struct {
        int    kind;
        int    code;
        int    r;
        int    c;
        string req;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;

    host_cmd_decoder #(.TIMEOUT_CYC(TMO)) u_dut (
        .clk(clk), .rst_n(rst_n), .rx_valid_i(rx_valid), .rx_byte_i(rx_byte),
        .rx_parity_err_i(rx_par), .sys_reset_o(sys_reset), .readout_o(readout),
        .cnt_clear_o(cnt_clear), .size_set_o(size_set), .size_rows_o(rows),
        .size_cols_o(cols), .inject_o(inject), .fault_valid_o(fault_valid),
        .fault_code_o(fault_code)
    );

    task automatic expect_ev(int kind, int code, int r, int c, string req);
        exp_t e;
        e.kind = kind; e.code = code; e.r = r; e.c = c; e.req = req;
        sb.push_back(e);
    endtask

    task automatic send(logic [7:0] b, logic par);
        @(negedge clk);
        rx_valid = 1'b1; rx_byte = b; rx_par = par;
        @(negedge clk);
        rx_valid = 1'b0; rx_byte = '0; rx_par = 1'b0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && !done) begin
            int n;
            int k;
            n = int'(sys_reset) + int'(readout) + int'(cnt_clear) + int'(size_set)
              + int'(inject) + int'(fault_valid);
            if (n > 1) begin
                checks++; errors++;
                $display("FAIL R11: %0d pulses in one cycle, expected at most 1", n);
            end
            if (!fault_valid && fault_code != 0) begin
                checks++; errors++;
                $display("FAIL R11: fault_code=%0d without fault, expected 0", fault_code);
            end
            if (n == 1) begin
                k = sys_reset ? 0 : readout ? 1 : cnt_clear ? 2 : size_set ? 3 : inject ? 4 : 5;
                checks++;
                if (sb.size() == 0) begin
                    errors++;
                    $display("FAIL R11: unexpected pulse kind %0d, expected none", k);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    if (k != e.kind) begin
                        errors++;
                        $display("FAIL %s: pulse kind %0d, expected %0d", e.req, k, e.kind);
                    end else if (k == 5 && int'(fault_code) != e.code) begin
                        errors++;
                        $display("FAIL %s: fault code %0d, expected %0d", e.req, fault_code, e.code);
                    end else if (k == 3 && (int'(rows) != e.r || int'(cols) != e.c)) begin
                        errors++;
                        $display("FAIL %s: size %0d/%0d, expected %0d/%0d", e.req, rows, cols, e.r, e.c);
                    end
                end
            end
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: run hung, actual not done, expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(3);
        // R1: reset state
        checks++;
        if ({sys_reset, readout, cnt_clear, size_set, inject, fault_valid} != 6'b0 || fault_code != 0) begin
            errors++;
            $display("FAIL R1: outputs %b code %0d during reset, expected 0",
                     {sys_reset, readout, cnt_clear, size_set, inject, fault_valid}, fault_code);
        end
        rst_n = 1'b1;
        idle(3);
        checks++;
        if ({sys_reset, readout, cnt_clear, size_set, inject, fault_valid} != 6'b0) begin
            errors++;
            $display("FAIL R1: pulse after reset release, expected none");
        end

        // R2 timing: pulse exactly in the cycle after acceptance
        @(negedge clk); rx_valid = 1'b1; rx_byte = 8'h01; rx_par = 1'b0;
        expect_ev(0, 0, 0, 0, "R2");
        @(negedge clk); rx_valid = 1'b0; rx_byte = '0;
        checks++;
        if (!sys_reset) begin
            errors++;
            $display("FAIL R2: sys_reset=%0b one cycle after byte, expected 1", sys_reset);
        end
        @(negedge clk);
        checks++;
        if (sys_reset) begin
            errors++;
            $display("FAIL R2: sys_reset=%0b two cycles after byte, expected 0", sys_reset);
        end

        expect_ev(1, 0, 0, 0, "R3"); send(8'h02, 1'b0);
        expect_ev(2, 0, 0, 0, "R4"); send(8'h03, 1'b0);
        expect_ev(4, 0, 0, 0, "R5"); send(8'h05, 1'b0);
        // R8: undefined opcodes
        expect_ev(5, 2, 0, 0, "R8"); send(8'h00, 1'b0);
        expect_ev(5, 2, 0, 0, "R8"); send(8'hFF, 1'b0);
        expect_ev(5, 2, 0, 0, "R8"); send(8'h06, 1'b0);
        // R9: parity on opcode, even a valid one
        expect_ev(5, 1, 0, 0, "R9"); send(8'h02, 1'b1);

        // R6: size edges
        expect_ev(3, 0, 10, 10, "R6"); send(8'h04, 1'b0); send(8'd10, 1'b0); send(8'd10, 1'b0);
        expect_ev(3, 0, 14, 13, "R6"); send(8'h04, 1'b0); send(8'd14, 1'b0); idle(3); send(8'd13, 1'b0);
        expect_ev(3, 0, 12, 11, "R6"); send(8'h04, 1'b0); send(8'd12, 1'b0); send(8'd11, 1'b0);
        // R7: out-of-range fields
        expect_ev(5, 3, 0, 0, "R7"); send(8'h04, 1'b0); send(8'd9,  1'b0); send(8'd12, 1'b0);
        expect_ev(5, 3, 0, 0, "R7"); send(8'h04, 1'b0); send(8'd15, 1'b0); send(8'd12, 1'b0);
        expect_ev(5, 3, 0, 0, "R7"); send(8'h04, 1'b0); send(8'd12, 1'b0); send(8'd14, 1'b0);
        expect_ev(5, 3, 0, 0, "R7"); send(8'h04, 1'b0); send(8'd12, 1'b0); send(8'd9,  1'b0);
        expect_ev(5, 3, 0, 0, "R7"); send(8'h04, 1'b0); send(8'd26, 1'b0); send(8'd10, 1'b0);

        // R9 in middle states, then R12 next byte is an opcode
        expect_ev(5, 1, 0, 0, "R9"); send(8'h04, 1'b0); send(8'd12, 1'b1);
        expect_ev(1, 0, 0, 0, "R12"); send(8'h02, 1'b0);
        expect_ev(5, 1, 0, 0, "R9"); send(8'h04, 1'b0); send(8'd12, 1'b0); send(8'd11, 1'b1);
        expect_ev(2, 0, 0, 0, "R12"); send(8'h03, 1'b0);

        // R10: timeout in row and column wait
        expect_ev(5, 4, 0, 0, "R10"); send(8'h04, 1'b0); idle(TMO + 4);
        expect_ev(4, 0, 0, 0, "R12"); send(8'h05, 1'b0);
        expect_ev(5, 4, 0, 0, "R10"); send(8'h04, 1'b0); send(8'd11, 1'b0); idle(TMO + 4);
        expect_ev(5, 2, 0, 0, "R12"); send(8'd11, 1'b0);
        // gap shorter than the timeout is tolerated
        expect_ev(3, 0, 11, 12, "R10"); send(8'h04, 1'b0); idle(TMO - 6); send(8'd11, 1'b0);
        idle(TMO - 6); send(8'd12, 1'b0);

        idle(6);
        done = 1'b1;
        checks++;
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL R11: %0d expected pulses never seen, expected 0", sb.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule